// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Receiver

This block turns serial stereo PCM into parallel samples. One bit clock and one frame clock are shared by up to three data lines. The frame clock marks which half of the frame is left and which is right. Each data line carries one stereo pair. The block runs on a fast system clock and oversamples the bit clock and the frame clock. It assumes both are synchronous to that system clock. A bit is taken on every rising edge of the bit clock.

Two framings are supported. In right-justified framing the word ends on the last bit clock of a half. In I2S framing the word starts one bit clock after the frame-clock edge. The word length and the frame-clock polarity can be chosen. In right-justified mode the block also watches the frame length and switches to 16-bit capture on its own when frames are packed. Configuration comes from register fields or, in hardware mode, from two strap inputs.

Each received word is placed MSB-aligned into a signed 24-bit result. For every data line the block presents a left and a right result. One valid strobe per frame covers all lines.

Top module: `aud_rx_top`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` is low and `left_o`/`right_o` are all zero until the first complete frame has been received.
- R2: A data bit and the frame-clock level are taken only at a rising bit-clock edge. A half boundary is a rising edge at which the frame-clock level differs from its level at the previous rising edge. Outputs change only in the system-clock cycle that follows a rising edge.
- R3: In right-justified mode the word is the last W bits received before a boundary, MSB first. Earlier bits of the half are ignored. The result is the word shifted left by 24−W with zeros below.
- R4: The 2-bit word-length field encodes 00 = 16, 01 = 20, 10 = 24, 11 = 18 bits.
- R5: In I2S mode the word-length field is ignored. The bit at the first edge after a boundary is skipped. The next up to 24 bits fill the result from bit 23 downwards. Bits beyond 24 are dropped, and bits a short half never delivers read as zero.
- R6: With polarity 0, a half in which the frame clock is high is left and a low half is right. Polarity 1 swaps the two.
- R7: Data line i drives bits [24i+23:24i] of `left_o` and `right_o`.
- R8: A frame is a left half followed by a right half. At the boundary that ends the right half, `valid_o` pulses high for one cycle and the left and right results of every line update together. The partial frame after reset produces no strobe.
- R9: In right-justified mode, two consecutive frames of exactly 32 rising edges make the block capture 16-bit words, whatever the word-length field says. A capture that falls on the same edge as the detector update uses the earlier setting. Any other frame length cancels packed capture.
- R10: With `hw_mode` high, `strap` selects 00 = 16-bit, 01 = 20-bit, 10 = 24-bit right-justified, or 11 = I2S. Polarity is fixed at 0, and the register fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_mode | input | 1 | 1 = strap configuration, 0 = register configuration |
| strap | input | 2 | Hardware format/word-length select |
| reg_i2s | input | 1 | Register field: 1 = I2S framing, 0 = right-justified |
| reg_wlen | input | 2 | Register field: word-length code |
| reg_pol | input | 1 | Register field: frame-clock polarity |
| bck | input | 1 | Serial bit clock |
| lrc | input | 1 | Frame (left/right) clock |
| sdata | input | LANES | Serial data lines |
| left_o | output | LANES*24 | Left results, 24 bits per line |
| right_o | output | LANES*24 | Right results, 24 bits per line |
| valid_o | output | 1 | One-cycle strobe per completed frame |

## Verification
The right-word capture at a left-start boundary and the packed-frame detector update fall on the same bit-clock edge. The capture must use the detector state from before that edge. This is provoked by a stream of 32-edge frames decoded with the 24-bit setting. The first two output frames must show 24-bit windows that straddle the half boundaries, with the second frame's right word taken in the cycle where detection becomes active. From the third frame on, the words must be 16-bit aligned. The bench computes each of these windows from the bits it sent.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  // half length (in bits) that makes a packed 16-bit frame
  localparam int PACK_HALF = 16;

  typedef struct packed {
    logic       i2s;
    logic       pol;
    logic [5:0] wbits;
  } aud_cfg_t;

  // word-length code is not in binary order
  function automatic logic [5:0] wl_decode(input logic [1:0] code);
    logic [5:0] w;
    unique case (code)
      2'b00:   w = 6'd16;
      2'b01:   w = 6'd20;
      2'b10:   w = 6'd24;
      default: w = 6'd18;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/aud_cfg_sel.sv
module aud_cfg_sel
  import aud_rx_pkg::*;
(
  input  logic       hw_mode,
  input  logic [1:0] strap,
  input  logic       reg_i2s,
  input  logic [1:0] reg_wlen,
  input  logic       reg_pol,
  output aud_cfg_t   cfg_o
);

  always_comb begin
    if (hw_mode) begin
      cfg_o.i2s   = (strap == 2'b11);
      cfg_o.pol   = 1'b0;
      cfg_o.wbits = wl_decode(strap);
    end else begin
      cfg_o.i2s   = reg_i2s;
      cfg_o.pol   = reg_pol;
      cfg_o.wbits = wl_decode(reg_wlen);
    end
  end

endmodule

// File: rtl/aud_frame_trk.sv
module aud_frame_trk
  import aud_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bck,
  input  logic             lrc,
  input  logic             pol,
  output logic             rise_o,
  output logic             bnd_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             cap_l_o,
  output logic             cap_r_o,
  output logic             pk_o
);

  localparam logic [CNT_W-1:0] CMAX   = '1;
  localparam logic [CNT_W-1:0] PK_LEN = CNT_W'(2 * PACK_HALF);

  logic             bck_q, lrc_q, start_q, sync_q, lok_q, hls_q, pk_q;
  logic             lrc_d, start_d, sync_d, lok_d, hls_d, pk_d;
  logic [1:0]       streak_q, streak_d;
  logic [CNT_W-1:0] pos_q, pos_d, cnt_q, cnt_d;
  logic             new_left, lstart;

  always_comb begin
    rise_o   = bck & ~bck_q;
    bnd_o    = rise_o & start_q & (lrc ^ lrc_q);
    new_left = lrc ^ pol;
    lstart   = bnd_o & new_left;
    cap_l_o  = bnd_o & sync_q & ~new_left;
    cap_r_o  = bnd_o & sync_q & new_left & lok_q;
    idx_o    = bnd_o ? '0 : pos_q;
    pk_o     = pk_q;

    lrc_d    = lrc_q;
    start_d  = start_q;
    sync_d   = sync_q;
    lok_d    = lok_q;
    hls_d    = hls_q;
    pos_d    = pos_q;
    cnt_d    = cnt_q;
    streak_d = streak_q;

    if (rise_o) begin
      lrc_d   = lrc;
      start_d = 1'b1;
      if (pos_q != CMAX) pos_d = pos_q + 1'b1;
      if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
    end
    if (bnd_o) begin
      sync_d = 1'b1;
      pos_d  = CNT_W'(1);
    end
    if (cap_l_o) lok_d = 1'b1;
    if (lstart) begin
      hls_d = 1'b1;
      cnt_d = CNT_W'(1);
      if (hls_q) begin
        if (cnt_q == PK_LEN) streak_d = (streak_q == 2'd2) ? 2'd2 : streak_q + 2'd1;
        else                 streak_d = 2'd0;
      end
    end
    pk_d = (streak_d == 2'd2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_q    <= 1'b0;
      lrc_q    <= 1'b0;
      start_q  <= 1'b0;
      sync_q   <= 1'b0;
      lok_q    <= 1'b0;
      hls_q    <= 1'b0;
      pk_q     <= 1'b0;
      streak_q <= 2'd0;
      pos_q    <= '0;
      cnt_q    <= '0;
    end else begin
      bck_q    <= bck;
      lrc_q    <= lrc_d;
      start_q  <= start_d;
      sync_q   <= sync_d;
      lok_q    <= lok_d;
      hls_q    <= hls_d;
      pk_q     <= pk_d;
      streak_q <= streak_d;
      pos_q    <= pos_d;
      cnt_q    <= cnt_d;
    end
  end

  // R9
  pk_at_lstart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pk_q) |-> $past(lstart));

endmodule

// File: rtl/aud_lane_cap.sv
module aud_lane_cap #(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise_i,
  input  logic                bnd_i,
  input  logic [CNT_W-1:0]    idx_i,
  input  logic                sd_i,
  input  logic                i2s_i,
  input  logic [5:0]          shamt_i,
  input  logic                cap_l_i,
  input  logic                cap_r_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);

  logic [SAMPLE_W-1:0] sr_q, sr_d, acc_q, acc_d, hold_q, hold_d;
  logic [SAMPLE_W-1:0] outl_d, outr_d, word;

  always_comb begin
    word   = i2s_i ? acc_q : (sr_q << shamt_i);
    sr_d   = sr_q;
    acc_d  = acc_q;
    hold_d = hold_q;
    outl_d = left_o;
    outr_d = right_o;
    if (rise_i) begin
      sr_d = {sr_q[SAMPLE_W-2:0], sd_i};
      if (bnd_i) acc_d = '0;
      else begin
        for (int b = 0; b < SAMPLE_W; b++) begin
          if (idx_i == CNT_W'(SAMPLE_W - b)) acc_d[b] = sd_i;
        end
      end
    end
    if (cap_l_i) hold_d = word;
    if (cap_r_i) begin
      outl_d = hold_q;
      outr_d = word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      acc_q   <= '0;
      hold_q  <= '0;
      left_o  <= '0;
      right_o <= '0;
    end else begin
      sr_q    <= sr_d;
      acc_q   <= acc_d;
      hold_q  <= hold_d;
      left_o  <= outl_d;
      right_o <= outr_d;
    end
  end

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rise_i) |-> ($stable(left_o) && $stable(right_o)));

endmodule

// File: rtl/aud_rx_top.sv
module aud_rx_top
  import aud_rx_pkg::*;
#(
  parameter int LANES    = 3,
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hw_mode,
  input  logic [1:0]                strap,
  input  logic                      reg_i2s,
  input  logic [1:0]                reg_wlen,
  input  logic                      reg_pol,
  input  logic                      bck,
  input  logic                      lrc,
  input  logic [LANES-1:0]          sdata,
  output logic [LANES*SAMPLE_W-1:0] left_o,
  output logic [LANES*SAMPLE_W-1:0] right_o,
  output logic                      valid_o
);

  localparam logic [5:0] PK_SH = 6'(SAMPLE_W - PACK_HALF);

  aud_cfg_t         cfg;
  logic             rise, bnd, cap_l, cap_r, pk;
  logic [CNT_W-1:0] idx;
  logic [5:0]       shamt;

  aud_cfg_sel u_cfg (
    .hw_mode (hw_mode),
    .strap   (strap),
    .reg_i2s (reg_i2s),
    .reg_wlen(reg_wlen),
    .reg_pol (reg_pol),
    .cfg_o   (cfg)
  );

  aud_frame_trk #(.CNT_W(CNT_W)) u_trk (
    .clk    (clk),
    .rst_n  (rst_n),
    .bck    (bck),
    .lrc    (lrc),
    .pol    (cfg.pol),
    .rise_o (rise),
    .bnd_o  (bnd),
    .idx_o  (idx),
    .cap_l_o(cap_l),
    .cap_r_o(cap_r),
    .pk_o   (pk)
  );

  always_comb begin
    if (!cfg.i2s && pk) shamt = PK_SH;
    else                shamt = 6'(SAMPLE_W) - cfg.wbits;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    aud_lane_cap #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise_i (rise),
      .bnd_i  (bnd),
      .idx_i  (idx),
      .sd_i   (sdata[g]),
      .i2s_i  (cfg.i2s),
      .shamt_i(shamt),
      .cap_l_i(cap_l),
      .cap_r_i(cap_r),
      .left_o (left_o[g*SAMPLE_W +: SAMPLE_W]),
      .right_o(right_o[g*SAMPLE_W +: SAMPLE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= cap_r;
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R2
  valid_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(rise));

endmodule

// File: tb/aud_rx_top_tb.sv
module aud_rx_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hw_mode;
  logic [1:0]  strap;
  logic        reg_i2s;
  logic [1:0]  reg_wlen;
  logic        reg_pol;
  logic        bck, lrc;
  logic [2:0]  sdata;
  logic [71:0] left_o, right_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;
  int nrx    = 0;
  bit done   = 0;

  logic [31:0] tx_l [0:7][0:2];
  logic [31:0] tx_r [0:7][0:2];
  logic [71:0] rx_l [0:7];
  logic [71:0] rx_r [0:7];

  always #2 clk = ~clk;

  aud_rx_top u_dut (
    .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .strap(strap),
    .reg_i2s(reg_i2s), .reg_wlen(reg_wlen), .reg_pol(reg_pol),
    .bck(bck), .lrc(lrc), .sdata(sdata),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always @(negedge clk) begin
    if (valid_o && nrx < 8) begin
      rx_l[nrx] = left_o;
      rx_r[nrx] = right_o;
      nrx = nrx + 1;
    end
  end

  function automatic logic [31:0] mix(input int f, input int l, input int h, input int s);
    logic [31:0] x;
    x = 32'(f * 131 + l * 17 + h * 7 + s * 1009 + 5);
    x = x * 32'h9E3779B1;
    x = x ^ (x >> 15);
    return x;
  endfunction

  function automatic int wl_bits(input int code);
    case (code)
      0: return 16;
      1: return 20;
      2: return 24;
      default: return 18;
    endcase
  endfunction

  function automatic logic [23:0] exp_word(input bit i2s, input logic [31:0] v, input int w, input int h);
    logic [23:0] e;
    e = '0;
    if (i2s) begin
      for (int k = 0; k < 24; k++) begin
        if (k + 1 <= w && k + 1 <= h - 1) e[23-k] = v[w-k-1];
      end
    end else begin
      e = 24'(v << (24 - w));
    end
    return e;
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bck = 1'b0; lrc = 1'b0; sdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic lv, input logic [2:0] d);
    @(negedge clk);
    bck = 1'b0; lrc = lv; sdata = d;
    @(negedge clk);
    @(negedge clk);
    bck = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_stream(input bit i2s, input int w, input int h, input bit pol,
                            input int nfr, input int seed);
    logic [31:0] msk, v;
    logic [2:0]  d;
    msk = (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    for (int f = 0; f < nfr; f++)
      for (int l = 0; l < 3; l++) begin
        tx_l[f][l] = mix(f, l, 0, seed) & msk;
        tx_r[f][l] = mix(f, l, 1, seed) & msk;
      end
    nrx = 0;
    lrc = pol;
    for (int f = 0; f < nfr; f++)
      for (int hs = 0; hs < 2; hs++)
        for (int j = 0; j < h; j++) begin
          for (int l = 0; l < 3; l++) begin
            v = (hs == 0) ? tx_l[f][l] : tx_r[f][l];
            if (i2s) d[l] = (j >= 1 && j <= w) ? v[w-j] : 1'b0;
            else     d[l] = (j >= h - w) ? v[w-1-(j-(h-w))] : 1'b1;
          end
          send_bit((hs == 0) ? ~pol : pol, d);
        end
    repeat (8) @(negedge clk);
  endtask

  task automatic compare_stream(input string req, input bit i2s, input int w, input int h, input int nfr);
    check_int({req, " R8 frame count"}, nrx, nfr - 2);
    for (int v = 0; v < nfr - 2; v++)
      for (int l = 0; l < 3; l++) begin
        check({req, " R7 left"},  rx_l[v][l*24 +: 24], exp_word(i2s, tx_l[v+1][l], w, h));
        check({req, " R7 right"}, rx_r[v][l*24 +: 24], exp_word(i2s, tx_r[v+1][l], w, h));
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    hw_mode = 1'b0; strap = 2'b00; reg_i2s = 1'b0; reg_wlen = 2'b00; reg_pol = 1'b0;
    do_reset();
    // R1: reset state
    check_int("R1 valid", int'(valid_o), 0);
    check("R1 left", left_o[23:0], 24'h0);
    check("R1 right", right_o[71:48], 24'h0);

    // register-mode sweep: framing x word-length code x polarity
    for (int fi = 0; fi < 2; fi++)
      for (int wl = 0; wl < 4; wl++)
        for (int p = 0; p < 2; p++) begin
          int w, h;
          string tag;
          do_reset();
          reg_i2s = fi[0]; reg_wlen = wl[1:0]; reg_pol = p[0];
          if (fi == 1) begin
            w = (wl % 2 == 1) ? 32 : 20;
            h = (wl % 2 == 1) ? 32 : 26;
            tag = "R5 R6";
          end else begin
            w = wl_bits(wl);
            h = w + 3 + p;
            tag = "R3 R4 R6 R2";
          end
          run_stream(fi[0], w, h, p[0], 6, fi * 8 + wl * 2 + p);
          compare_stream(tag, fi[0], w, h, 6);
        end

    // R3: right-justified word filling the whole half
    do_reset();
    reg_i2s = 1'b0; reg_wlen = 2'b10; reg_pol = 1'b0;
    run_stream(1'b0, 24, 24, 1'b0, 6, 40);
    compare_stream("R3 full half", 1'b0, 24, 24, 6);

    // R10: strap mode, register fields set to misleading values
    for (int s = 0; s < 4; s++) begin
      int w, h;
      do_reset();
      hw_mode = 1'b1; strap = s[1:0];
      reg_pol = 1'b1; reg_wlen = 2'b11; reg_i2s = (s != 3);
      if (s == 3) begin w = 19; h = 20; end
      else begin w = wl_bits(s); h = w + 5; end
      run_stream(s == 3, w, h, 1'b0, 6, 50 + s);
      compare_stream("R10", s == 3, w, h, 6);
    end
    hw_mode = 1'b0;

    // R9: packed 16-bit frames while configured for 24 bits
    do_reset();
    reg_i2s = 1'b0; reg_wlen = 2'b10; reg_pol = 1'b0;
    run_stream(1'b0, 16, 16, 1'b0, 6, 60);
    check_int("R9 R8 frame count", nrx, 4);
    for (int v = 0; v < 4; v++)
      for (int l = 0; l < 3; l++) begin
        logic [23:0] el, er;
        int f;
        f = v + 1;
        if (v < 2) begin
          el = {tx_r[f-1][l][7:0], tx_l[f][l][15:0]};
          er = {tx_l[f][l][7:0],   tx_r[f][l][15:0]};
        end else begin
          el = {tx_l[f][l][15:0], 8'h00};
          er = {tx_r[f][l][15:0], 8'h00};
        end
        check("R9 left",  rx_l[v][l*24 +: 24], el);
        check("R9 right", rx_r[v][l*24 +: 24], er);
      end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule